// File: doc/BRIEF.md
# Line Data Steering with All-Ones Generation

This block sits between the framer side and the line side of a single-channel line interface. It steers dual-rail data (a positive rail and a negative rail) and the matching clocks between the transmit inputs, the received line data and the smoothed output of a jitter attenuator. A 2-bit loopback code picks one of four routings. An all-ones request replaces the line transmit data with a continuous bipolar mark pattern, timed by the reference clock that also clocks this block.

The line-side transmit rails are registered on the reference clock, so each bit reaches the line one clock after it is presented. The receive-side outputs (data and clock) are pure selections with no register, because a recovered or looped clock is routed through them. A strap input lets the receive-loss indication raise the all-ones request on its own, for as long as loss is present. The all-ones request has no enable and no register interface: it takes effect on the next clock edge.

Top module: `loopback_ais_steer`

## Requirements
- R1: While rst_n is low, line_pos_o, line_neg_o and the all-ones pattern phase are held at 0, so both line rails read 0 in the first cycle after reset.
- R2: With loop_sel_i = 00 (normal) and no all-ones in effect, the line rails carry tx_pos_i/tx_neg_i one clock later, and rd_pos_o/rd_neg_o/rd_clk_o follow rx_pos_i/rx_neg_i/rx_clk_i with no delay.
- R3: The all-ones condition is in effect when loop_sel_i is not 10 and either ais_req_i is 1, or auto_ais_i and rx_loss_i are both 1. ais_on_o shows this condition with no delay.
- R4: While all-ones is in effect, the line output carries exactly one mark per clock. The first clock of a burst marks the positive rail, and after that the rails alternate every clock. tx_pos_i and tx_neg_i have no effect on the line during the burst.
- R5: With auto_ais_i = 0, rx_loss_i has no effect on the line rails or on ais_on_o.
- R6: With loop_sel_i = 10 (remote loopback), the line rails carry rx_pos_i/rx_neg_i one clock later, and ais_req_i and rx_loss_i are ignored. The receive outputs still follow the received line data.
- R7: With loop_sel_i = 01 (digital local loopback), rd_pos_o/rd_neg_o/rd_clk_o follow tx_pos_i/tx_neg_i/tx_clk_i. The line rails still carry the transmit data, or the all-ones pattern when it is in effect.
- R8: With loop_sel_i = 11 and ja_mode_i = 01 (jitter attenuator in the transmit path), rd_pos_o/rd_neg_o/rd_clk_o follow ja_pos_i/ja_neg_i/ja_clk_i. The line keeps carrying the transmit data, or the all-ones pattern when it is in effect.
- R9: With loop_sel_i = 11 and any other ja_mode_i value, the local loopback has no effect: the receive outputs follow the received line data.
- R10: The line rails never both carry a mark at the same time unless the selected source data has both rails set; in particular never during all-ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; one line bit per rising edge |
| rst_n | input | 1 | Active-low reset of the line registers |
| loop_sel_i | input | 2 | Loopback code: 00 normal, 01 digital local, 10 remote, 11 local |
| ja_mode_i | input | 2 | Jitter attenuator placement; 01 means in transmit path |
| ais_req_i | input | 1 | All-ones request, acts without gating |
| auto_ais_i | input | 1 | Strap: receive loss raises all-ones |
| rx_loss_i | input | 1 | Receive loss indication |
| tx_pos_i | input | 1 | Transmit positive rail data |
| tx_neg_i | input | 1 | Transmit negative rail data |
| tx_clk_i | input | 1 | Transmit clock |
| rx_pos_i | input | 1 | Received positive rail data |
| rx_neg_i | input | 1 | Received negative rail data |
| rx_clk_i | input | 1 | Recovered receive clock |
| ja_pos_i | input | 1 | Jitter attenuator output, positive rail |
| ja_neg_i | input | 1 | Jitter attenuator output, negative rail |
| ja_clk_i | input | 1 | Jitter attenuator smoothed clock |
| line_pos_o | output | 1 | Registered line positive rail |
| line_neg_o | output | 1 | Registered line negative rail |
| rd_pos_o | output | 1 | Receive positive rail to the system side |
| rd_neg_o | output | 1 | Receive negative rail to the system side |
| rd_clk_o | output | 1 | Receive clock to the system side |
| ais_on_o | output | 1 | All-ones condition currently in effect |

## Verification
The bench walks every combination of loopback code, attenuator mode, request, strap, loss and data bits, and changes them every clock. This makes all-ones bursts start and stop at many points. A design that carried the pattern phase over from a previous burst would start a burst on the negative rail. A design that let the request override remote loopback would send marks in place of the echoed data. A design that honoured local loopback without the attenuator mode check would show attenuator data on the receive pins when that data is not valid. The sweep also pairs loss with the strap cleared, so a loss path that ignored the strap would start a pattern that should not appear.

// File: rtl/lbsel_pkg.sv
package lbsel_pkg;
    localparam int SEL_W  = 2;
    localparam int MODE_W = 2;

    typedef enum logic [SEL_W-1:0] {
        LB_NORMAL = 2'b00,
        LB_DIGLOC = 2'b01,
        LB_REMOTE = 2'b10,
        LB_LOCAL  = 2'b11
    } lb_mode_e;

    localparam logic [MODE_W-1:0] JA_IN_TX = 2'b01;

    typedef struct packed {
        logic pos;
        logic neg;
    } rail_t;

    typedef struct packed {
        rail_t line;
        logic  phase;
    } line_state_t;
endpackage

// File: rtl/lbsel_decode.sv
module lbsel_decode
    import lbsel_pkg::*;
(
    input  logic [SEL_W-1:0]  loop_sel,
    input  logic [MODE_W-1:0] ja_mode,
    input  logic              ais_req,
    input  logic              auto_ais,
    input  logic              rx_loss,
    output lb_mode_e          mode,
    output logic              ais_eff,
    output logic              use_ja
);
    logic ais_raw;

    always_comb begin
        mode    = lb_mode_e'(loop_sel);
        ais_raw = ais_req | (auto_ais & rx_loss);
        ais_eff = ais_raw & (mode != LB_REMOTE);
        use_ja  = (mode == LB_LOCAL) && (ja_mode == JA_IN_TX);
    end
endmodule

// File: rtl/lbsel_line.sv
module lbsel_line
    import lbsel_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  lb_mode_e mode,
    input  logic     ais_eff,
    input  rail_t    tx_rail,
    input  rail_t    rx_rail,
    output rail_t    line
);
    line_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ais_eff) begin
            st_d.line.pos = ~st_q.phase;
            st_d.line.neg = st_q.phase;
            st_d.phase    = ~st_q.phase;
        end else begin
            st_d.phase = 1'b0;
            if (mode == LB_REMOTE) st_d.line = rx_rail;
            else                   st_d.line = tx_rail;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign line = st_q.line;

    // R4
    ais_single_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ais_eff |=> (line.pos ^ line.neg));

    // R4
    ais_alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ais_eff && $past(ais_eff) && line.pos) |=> line.neg);

    // R4
    ais_first_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ais_eff) |=> line.pos);

    // R6
    remote_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == LB_REMOTE) |=> (line == $past(rx_rail)));

    // R10
    ais_no_dual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ais_eff |=> !(line.pos && line.neg));
endmodule

// File: rtl/lbsel_rx_steer.sv
module lbsel_rx_steer
    import lbsel_pkg::*;
(
    input  lb_mode_e mode,
    input  logic     use_ja,
    input  rail_t    tx_rail,
    input  logic     tx_clk,
    input  rail_t    rx_rail,
    input  logic     rx_clk,
    input  rail_t    ja_rail,
    input  logic     ja_clk,
    output rail_t    rd_rail,
    output logic     rd_clk
);
    always_comb begin
        if (mode == LB_DIGLOC) begin
            rd_rail = tx_rail;
            rd_clk  = tx_clk;
        end else if (use_ja) begin
            rd_rail = ja_rail;
            rd_clk  = ja_clk;
        end else begin
            rd_rail = rx_rail;
            rd_clk  = rx_clk;
        end
    end
endmodule

// File: rtl/loopback_ais_steer.sv
module loopback_ais_steer
    import lbsel_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  loop_sel_i,
    input  logic [MODE_W-1:0] ja_mode_i,
    input  logic              ais_req_i,
    input  logic              auto_ais_i,
    input  logic              rx_loss_i,
    input  logic              tx_pos_i,
    input  logic              tx_neg_i,
    input  logic              tx_clk_i,
    input  logic              rx_pos_i,
    input  logic              rx_neg_i,
    input  logic              rx_clk_i,
    input  logic              ja_pos_i,
    input  logic              ja_neg_i,
    input  logic              ja_clk_i,
    output logic              line_pos_o,
    output logic              line_neg_o,
    output logic              rd_pos_o,
    output logic              rd_neg_o,
    output logic              rd_clk_o,
    output logic              ais_on_o
);
    lb_mode_e mode;
    logic     ais_eff, use_ja;
    rail_t    tx_rail, rx_rail, ja_rail, line, rd_rail;

    assign tx_rail = '{pos: tx_pos_i, neg: tx_neg_i};
    assign rx_rail = '{pos: rx_pos_i, neg: rx_neg_i};
    assign ja_rail = '{pos: ja_pos_i, neg: ja_neg_i};

    lbsel_decode u_dec (
        .loop_sel (loop_sel_i),
        .ja_mode  (ja_mode_i),
        .ais_req  (ais_req_i),
        .auto_ais (auto_ais_i),
        .rx_loss  (rx_loss_i),
        .mode     (mode),
        .ais_eff  (ais_eff),
        .use_ja   (use_ja)
    );

    lbsel_line u_line (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode),
        .ais_eff (ais_eff),
        .tx_rail (tx_rail),
        .rx_rail (rx_rail),
        .line    (line)
    );

    lbsel_rx_steer u_rx (
        .mode    (mode),
        .use_ja  (use_ja),
        .tx_rail (tx_rail),
        .tx_clk  (tx_clk_i),
        .rx_rail (rx_rail),
        .rx_clk  (rx_clk_i),
        .ja_rail (ja_rail),
        .ja_clk  (ja_clk_i),
        .rd_rail (rd_rail),
        .rd_clk  (rd_clk_o)
    );

    assign line_pos_o = line.pos;
    assign line_neg_o = line.neg;
    assign rd_pos_o   = rd_rail.pos;
    assign rd_neg_o   = rd_rail.neg;
    assign ais_on_o   = ais_eff;

    // R2
    normal_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_sel_i == 2'b00 && !ais_on_o) |=>
        (line_pos_o == $past(tx_pos_i) && line_neg_o == $past(tx_neg_i)));

    // R6
    remote_no_ais_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_sel_i == 2'b10) |-> !ais_on_o);

    // R5
    loss_needs_strap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_ais_i && !ais_req_i) |-> !ais_on_o);

    // R9
    local_nomode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_sel_i == 2'b11 && ja_mode_i != 2'b01) |->
        (rd_pos_o == rx_pos_i && rd_neg_o == rx_neg_i && rd_clk_o == rx_clk_i));
endmodule

// File: tb/loopback_ais_steer_test.sv
module loopback_ais_steer_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] loop_sel = 2'b00, ja_mode = 2'b00;
    logic ais_req = 0, auto_ais = 0, rx_loss = 0;
    logic tx_pos = 0, tx_neg = 0, tx_clk = 0;
    logic rx_pos = 0, rx_neg = 0, rx_clk = 0;
    logic ja_pos = 0, ja_neg = 0, ja_clk = 0;
    logic line_pos, line_neg, rd_pos, rd_neg, rd_clk, ais_on;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    loopback_ais_steer uut (
        .clk(clk), .rst_n(rst_n), .loop_sel_i(loop_sel), .ja_mode_i(ja_mode),
        .ais_req_i(ais_req), .auto_ais_i(auto_ais), .rx_loss_i(rx_loss),
        .tx_pos_i(tx_pos), .tx_neg_i(tx_neg), .tx_clk_i(tx_clk),
        .rx_pos_i(rx_pos), .rx_neg_i(rx_neg), .rx_clk_i(rx_clk),
        .ja_pos_i(ja_pos), .ja_neg_i(ja_neg), .ja_clk_i(ja_clk),
        .line_pos_o(line_pos), .line_neg_o(line_neg),
        .rd_pos_o(rd_pos), .rd_neg_o(rd_neg), .rd_clk_o(rd_clk), .ais_on_o(ais_on)
    );

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    initial begin
        #400000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hang expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic exp_pos, exp_neg, phase, aeff, line_rails_tag;
        exp_pos = 0; exp_neg = 0; phase = 0;
        repeat (3) @(negedge clk);
        // R1: reset holds both rails low
        check("R1 pos", int'(line_pos), 0);
        check("R1 neg", int'(line_neg), 0);
        rst_n = 1'b1;
        for (int i = 0; i < 32768; i++) begin
            @(negedge clk);
            // line result of previous stimulus (one register)
            if (i > 0) begin
                check("R2/R4/R6 line pos", int'(line_pos), int'(exp_pos));
                check("R2/R4/R6 line neg", int'(line_neg), int'(exp_neg));
                // R10
                if (aeff) check("R10 dual mark", int'(line_pos & line_neg), 0);
            end
            loop_sel = i[1:0];
            ja_mode  = i[3:2];
            ais_req  = i[4];
            auto_ais = i[5];
            rx_loss  = i[6];
            tx_pos = i[7];  tx_neg = i[8];
            rx_pos = i[9];  rx_neg = i[10];
            ja_pos = i[11]; ja_neg = i[12];
            tx_clk = i[13]; rx_clk = i[14] ^ i[0]; ja_clk = ~i[13];
            #1;
            // R3, R5: all-ones condition
            aeff = (loop_sel != 2'b10) && (ais_req || (auto_ais && rx_loss));
            check("R3/R5 ais_on", int'(ais_on), int'(aeff));
            // receive steering
            if (loop_sel == 2'b01) begin
                check("R7 rd pos", int'(rd_pos), int'(tx_pos));
                check("R7 rd neg", int'(rd_neg), int'(tx_neg));
                check("R7 rd clk", int'(rd_clk), int'(tx_clk));
            end else if (loop_sel == 2'b11 && ja_mode == 2'b01) begin
                check("R8 rd pos", int'(rd_pos), int'(ja_pos));
                check("R8 rd neg", int'(rd_neg), int'(ja_neg));
                check("R8 rd clk", int'(rd_clk), int'(ja_clk));
            end else begin
                check("R2/R6/R9 rd pos", int'(rd_pos), int'(rx_pos));
                check("R2/R6/R9 rd neg", int'(rd_neg), int'(rx_neg));
                check("R2/R6/R9 rd clk", int'(rd_clk), int'(rx_clk));
            end
            // expected line at next edge
            if (aeff) begin
                exp_pos = ~phase;
                exp_neg = phase;
                phase = ~phase;
            end else begin
                phase = 0;
                if (loop_sel == 2'b10) begin
                    exp_pos = rx_pos; exp_neg = rx_neg;
                end else begin
                    exp_pos = tx_pos; exp_neg = tx_neg;
                end
            end
        end
        // R4: dedicated burst with changing tx data
        @(negedge clk);
        loop_sel = 2'b00; ais_req = 0; auto_ais = 0; rx_loss = 0;
        @(negedge clk);
        ais_req = 1;
        for (int k = 0; k < 8; k++) begin
            tx_pos = k[0]; tx_neg = k[1];
            @(negedge clk);
            check("R4 burst pos", int'(line_pos), (k % 2 == 0) ? 1 : 0);
            check("R4 burst neg", int'(line_neg), (k % 2 == 0) ? 0 : 1);
        end
        // R1: reset mid-burst clears rails
        rst_n = 1'b0;
        #1;
        check("R1 async pos", int'(line_pos), 0);
        check("R1 async neg", int'(line_neg), 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule